// File: doc/BRIEF.md
# Dual-Role Byte-Wide SPI Port

This block moves one byte at a time over a four-wire synchronous serial link. It can drive the link as the clock owner (master) or follow a clock from the link (slave). A 4-bit mode input picks the role and, for the master, where the serial clock comes from. The master can divide the system clock by 4, 16 or 64, or it can toggle the serial clock once per pulse of an external timer tick. The slave can honour a select pin or ignore it. A polarity input sets the level the serial clock rests at. Data goes out MSB first. The output bit changes on the clock edge that leaves the rest level, and the input bit is sampled on the edge that returns to it.

The transmit side is a valid/ready input. `tx_ready` is high only when the port is enabled, is in a legal mode and has no byte in progress. A beat with `tx_valid` high and `tx_ready` low is dropped and never stalls the producer. If that beat arrived during a byte in progress, it sets the sticky write-collision flag.

The receive side is a valid/ready output that acts as a one-byte buffer. `rx_valid` stays high, with `rx_data` stable, until a cycle with `rx_ready` high takes the byte. A master that finishes a byte always overwrites the buffer. A slave that finishes a byte while the buffer is still full sets the sticky overflow flag and drops the new byte. Each sticky flag clears only on its own clear pulse.

Top module: `spi_port`

## Requirements
- R1: In mode 4'b0000 the master serial clock changes level every 2 system clocks. In mode 4'b0001 it changes every 8 system clocks, and in mode 4'b0010 every 32.
- R2: In mode 4'b0011 the master serial clock changes level once per `tmr_tick` pulse, so a tick every 5 clocks gives a half period of 5 clocks.
- R3: A transfer moves 8 bits MSB first: `sdo_o` changes on the edge leaving the rest level and `sdi_i` is sampled on the edge returning to it. The received byte then appears on `rx_data` with `rx_valid` high, and `rx_valid` stays high until a cycle with `rx_ready` high takes the byte.
- R4: With `cfg_cpol` = 1 the serial clock rests high; with 0 it rests low. A transfer returns the clock to that level.
- R5: In mode 4'b0101 the port is a slave clocked by `sck_i`, `ss_n_i` has no effect, and `sdo_oe` is high. A byte loaded through `tx_valid` beforehand goes out on `sdo_o`.
- R6: In mode 4'b0100, while `ss_n_i` is high the slave ignores `sck_i` and holds `sdo_oe` low. A rise of `ss_n_i` in the middle of a byte drops the bits received so far, so the next select starts a fresh byte.
- R7: A `tx_valid` beat during a byte in progress sets `wcol`, and the byte in flight is unchanged. `wcol` stays set until a `wcol_clr` pulse.
- R8: In a slave mode, a byte that completes while `rx_valid` is high and `rx_ready` is low sets `rov`, and `rx_data` keeps the older byte. `rov` stays set until a `rov_clr` pulse.
- R9: In master modes `rov` never sets. A completed byte replaces an unread one in the buffer.
- R10: Mode codes 4'b0110 to 4'b1111 start no transfer: `tx_ready` is low, the serial clock is not driven, and a `tx_valid` beat changes neither `wcol` nor `rx_valid`.
- R11: With `cfg_en` low, `sck_oe` and `sdo_oe` are low and `tx_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_en | input | 1 | Port enable; when low the serial pins are released |
| cfg_cpol | input | 1 | Serial clock rest level |
| cfg_mode | input | 4 | Role and clock-source select |
| tmr_tick | input | 1 | External timer tick (mode 4'b0011) |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Port can accept a transmit byte |
| rx_valid | output | 1 | Receive buffer holds a byte |
| rx_data | output | 8 | Received byte |
| rx_ready | input | 1 | Consumer takes the received byte |
| wcol | output | 1 | Sticky write-collision flag |
| wcol_clr | input | 1 | Clears `wcol` |
| rov | output | 1 | Sticky slave receive-overflow flag |
| rov_clr | input | 1 | Clears `rov` |
| sck_i | input | 1 | Serial clock from the link (slave) |
| sck_o | output | 1 | Serial clock to the link (master) |
| sck_oe | output | 1 | Drive enable for `sck_o` |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for `sdo_o` |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
The assertions check four behaviours on every cycle. An idle master holds the clock at the rest level. A master byte ends on its eighth returning edge. The sticky flags stay set until cleared, and an overflow leaves the buffer untouched. Deselecting the slave, or leaving the legal modes, clears any partial byte. Only the bench scenarios can show the serial content itself: the byte order, the half-period length for each clock source, and that a slave byte abandoned by deselect leaves no trace in the byte that follows.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  typedef enum logic [3:0] {
    MD_MST_DIV4  = 4'd0,
    MD_MST_DIV16 = 4'd1,
    MD_MST_DIV64 = 4'd2,
    MD_MST_TMR   = 4'd3,
    MD_SLV_SEL   = 4'd4,
    MD_SLV_FREE  = 4'd5
  } mode_e;

  function automatic logic is_master(logic [3:0] m);
    return m[3:2] == 2'b00;
  endfunction

  function automatic logic is_slave(logic [3:0] m);
    return (m == MD_SLV_SEL) || (m == MD_SLV_FREE);
  endfunction
endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST;
      q_o  <= RST;
    end else begin
      meta <= d_i;
      q_o  <= meta;
    end
  end
endmodule

// File: rtl/spi_port_clkgen.sv
module spi_port_clkgen #(
  parameter int BASE_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  input  logic       tmr_tick,
  output logic       half_o
);
  localparam int MAX_HALF = BASE_HALF << 4;
  localparam int CW       = $clog2(MAX_HALF + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          timer;
  logic          wrap;

  // half period grows by 4x per select step
  always_comb begin
    timer = (sel == 2'b11);
    lim   = CW'(BASE_HALF) << {sel, 1'b0};
    wrap  = (cnt == lim - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (!run || timer || wrap) cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end

  assign half_o = run & (timer ? tmr_tick : wrap);
endmodule

// File: rtl/spi_port_engine.sv
module spi_port_engine #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master,
  input  logic          slave_act,
  input  logic          cpol,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          half_tick,
  input  logic          sdi_raw,
  input  logic          s_sck,
  input  logic          s_sdi,
  output logic          sck,
  output logic          sdo,
  output logic          busy,
  output logic          run,
  output logic          done,
  output logic [DW-1:0] rx_byte
);
  localparam int CNT_W = $clog2(DW + 1);

  logic [DW-1:0]    shreg;
  logic [CNT_W-1:0] bitcnt;
  logic             mbusy, sck_q, sdo_q, done_q, sck_d;
  logic             s_lead, s_trail, last;

  always_comb begin
    s_lead  = (s_sck ^ sck_d) & (s_sck != cpol);
    s_trail = (s_sck ^ sck_d) & (s_sck == cpol);
    last    = (bitcnt == CNT_W'(DW - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0; bitcnt <= '0; mbusy <= 1'b0;
      sck_q <= 1'b0; sdo_q <= 1'b0; done_q <= 1'b0; sck_d <= 1'b0;
    end else begin
      done_q <= 1'b0;
      sck_d  <= s_sck;
      if (load) begin
        shreg  <= load_data;
        mbusy  <= master;
        bitcnt <= '0;
        sck_q  <= cpol;
        sdo_q  <= load_data[DW-1];
      end else if (master) begin
        if (!mbusy) begin
          sck_q  <= cpol;
          bitcnt <= '0;
        end else if (half_tick) begin
          if (sck_q == cpol) begin
            sck_q <= ~cpol;
            sdo_q <= shreg[DW-1];
          end else begin
            sck_q <= cpol;
            shreg <= {shreg[DW-2:0], sdi_raw};
            if (last) begin
              bitcnt <= '0; mbusy <= 1'b0; done_q <= 1'b1;
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
      end else if (slave_act) begin
        mbusy <= 1'b0;
        sck_q <= cpol;
        if (s_lead) sdo_q <= shreg[DW-1];
        if (s_trail) begin
          shreg <= {shreg[DW-2:0], s_sdi};
          if (last) begin
            bitcnt <= '0; done_q <= 1'b1;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
      end else begin
        mbusy  <= 1'b0;
        bitcnt <= '0;
        sck_q  <= cpol;
      end
    end
  end

  assign sck     = sck_q;
  assign sdo     = sdo_q;
  assign busy    = mbusy | (bitcnt != '0);
  assign run     = mbusy & master;
  assign done    = done_q;
  assign rx_byte = shreg;

  assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !mbusy && !load) |=> (sck == $past(cpol)));

  assert_master_byte_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (master && mbusy && !load && half_tick && (sck_q != cpol) && last) |=> (done && !busy));

  assert_deselect_abandons_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && !slave_act && !load) |=> !busy);
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DW        = 8,
  parameter int BASE_HALF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic          cfg_cpol,
  input  logic [3:0]    cfg_mode,
  input  logic          tmr_tick,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  output logic          tx_ready,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  input  logic          rx_ready,
  output logic          wcol,
  input  logic          wcol_clr,
  output logic          rov,
  input  logic          rov_clr,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          sdi_i,
  output logic          sdo_o,
  output logic          sdo_oe,
  input  logic          ss_n_i
);
  logic          mst, slv, slave_act, pop, load;
  logic          s_sck, s_sdi, s_ss_n;
  logic          half_tick, eng_busy, eng_run, eng_done, eng_sck, eng_sdo;
  logic [DW-1:0] eng_byte;

  spi_port_sync #(.W(3), .RST(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({ss_n_i, sdi_i, sck_i}),
    .q_o({s_ss_n, s_sdi, s_sck})
  );

  always_comb begin
    mst       = cfg_en & is_master(cfg_mode);
    slv       = cfg_en & is_slave(cfg_mode);
    slave_act = slv & ((cfg_mode != MD_SLV_SEL) | ~s_ss_n);
    tx_ready  = (mst | slv) & ~eng_busy;
    load      = tx_valid & tx_ready;
    pop       = rx_valid & rx_ready;
  end

  spi_port_clkgen #(.BASE_HALF(BASE_HALF)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(eng_run), .sel(cfg_mode[1:0]),
    .tmr_tick(tmr_tick), .half_o(half_tick)
  );

  spi_port_engine #(.DW(DW)) u_engine (
    .clk(clk), .rst_n(rst_n), .master(mst), .slave_act(slave_act),
    .cpol(cfg_cpol), .load(load), .load_data(tx_data), .half_tick(half_tick),
    .sdi_raw(sdi_i), .s_sck(s_sck), .s_sdi(s_sdi),
    .sck(eng_sck), .sdo(eng_sdo), .busy(eng_busy), .run(eng_run),
    .done(eng_done), .rx_byte(eng_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0; rx_data <= '0; wcol <= 1'b0; rov <= 1'b0;
    end else begin
      if (wcol_clr) wcol <= 1'b0;
      if (tx_valid && (mst || slv) && eng_busy) wcol <= 1'b1;
      if (rov_clr) rov <= 1'b0;
      if (eng_done) begin
        if (slv && rx_valid && !pop) begin
          rov <= 1'b1;
        end else begin
          rx_data  <= eng_byte;
          rx_valid <= 1'b1;
        end
      end else if (pop) begin
        rx_valid <= 1'b0;
      end
    end
  end

  assign sck_o  = eng_sck;
  assign sck_oe = mst;
  assign sdo_o  = eng_sdo;
  assign sdo_oe = mst | slave_act;

  assert_wcol_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wcol && !wcol_clr) |=> wcol);

  assert_no_rov_master_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mst && !rov) |=> !rov);

  assert_rov_keeps_buffer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (slv && eng_done && rx_valid && !rx_ready) |=> (rov && $stable(rx_data)));
endmodule

// File: tb/test_spi_port.sv
module test_spi_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       cfg_en, cfg_cpol, tmr_tick, tx_valid, rx_ready, wcol_clr, rov_clr;
  logic [3:0] cfg_mode;
  logic [7:0] tx_data, rx_data;
  logic       tx_ready, rx_valid, wcol, rov;
  logic       sck_i, sck_o, sck_oe, sdi_i, sdo_o, sdo_oe, ss_n_i;

  spi_port i_spi_port (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_cpol(cfg_cpol), .cfg_mode(cfg_mode),
    .tmr_tick(tmr_tick), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready), .wcol(wcol),
    .wcol_clr(wcol_clr), .rov(rov), .rov_clr(rov_clr), .sck_i(sck_i), .sck_o(sck_o),
    .sck_oe(sck_oe), .sdi_i(sdi_i), .sdo_o(sdo_o), .sdo_oe(sdo_oe), .ss_n_i(ss_n_i)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  task automatic check_eq(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard queues
  logic [7:0] exp_tx[$];
  string      exp_tx_req[$];
  logic [7:0] exp_rx[$];
  string      exp_rx_req[$];

  // master-side responder and monitor
  logic [7:0] resp = 8'h00;
  logic [7:0] cap  = 8'h00;
  int         ridx = 0;
  bit         mon_on = 0;
  time        t_last = 0;
  int         half_cyc = 0;

  always @(sck_o) begin
    if (mon_on) begin
      half_cyc = int'(($time - t_last) / 20);
      t_last   = $time;
      if (sck_o != cfg_cpol) begin
        sdi_i = resp[7 - ridx];
      end else begin
        cap = {cap[6:0], sdo_o};
        ridx++;
        if (ridx == 8) begin
          ridx = 0;
          if (exp_tx.size() == 0) check_eq("R3", "unexpected tx byte", cap, 0);
          else check_eq(exp_tx_req.pop_front(), "tx byte on sdo_o", cap, exp_tx.pop_front());
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      if (exp_rx.size() == 0) check_eq("R3", "unexpected rx byte", rx_data, 256);
      else check_eq(exp_rx_req.pop_front(), "rx byte", rx_data, exp_rx.pop_front());
    end
  end

  bit tick_en = 0;
  initial begin
    tmr_tick = 1'b0;
    forever begin
      repeat (4) @(negedge clk);
      tmr_tick = tick_en;
      @(negedge clk);
      tmr_tick = 1'b0;
    end
  end

  task automatic set_cfg(bit en, bit pol, logic [3:0] m);
    @(negedge clk);
    cfg_en = en; cfg_cpol = pol; cfg_mode = m;
    repeat (3) @(negedge clk);
  endtask

  task automatic write_byte(logic [7:0] b);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = b;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (!tx_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic mst_xfer(logic [7:0] tx, logic [7:0] rsp, string req, bit want_rx);
    resp = rsp; ridx = 0; mon_on = 1;
    exp_tx.push_back(tx); exp_tx_req.push_back(req);
    if (want_rx) begin exp_rx.push_back(rsp); exp_rx_req.push_back(req); end
    write_byte(tx);
    wait_idle();
    mon_on = 0;
  endtask

  logic [7:0] scap = 8'h00;
  task automatic slv_bits(logic [7:0] din, int nbits);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      sck_i = ~cfg_cpol; sdi_i = din[7 - i];
      repeat (8) @(negedge clk);
      scap = {scap[6:0], sdo_o};
      sck_i = cfg_cpol;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 190000);
    n_checks++; n_fail++;
    $display("FAIL R3 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cfg_en = 0; cfg_cpol = 0; cfg_mode = 4'd0; tx_valid = 0; tx_data = 8'h00;
    rx_ready = 1; wcol_clr = 0; rov_clr = 0; sck_i = 0; sdi_i = 0; ss_n_i = 1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R3", "reset rx_valid", rx_valid, 0);
    check_eq("R7", "reset wcol", wcol, 0);
    check_eq("R8", "reset rov", rov, 0);

    // R11: disabled port releases pins and refuses bytes
    check_eq("R11", "disabled sck_oe", sck_oe, 0);
    check_eq("R11", "disabled sdo_oe", sdo_oe, 0);
    check_eq("R11", "disabled tx_ready", tx_ready, 0);

    // R1: three prescaled master clocks, R3 byte exchange
    set_cfg(1, 0, 4'b0000);
    check_eq("R4", "idle low sck_o", sck_o, 0);
    check_eq("R11", "enabled master sck_oe", sck_oe, 1);
    mst_xfer(8'hA5, 8'h3C, "R3", 1);
    check_eq("R1", "half period div4", half_cyc, 2);
    set_cfg(1, 0, 4'b0001);
    mst_xfer(8'h81, 8'h7E, "R1", 1);
    check_eq("R1", "half period div16", half_cyc, 8);
    set_cfg(1, 0, 4'b0010);
    mst_xfer(8'h0F, 8'hF0, "R1", 1);
    check_eq("R1", "half period div64", half_cyc, 32);

    // R2: timer-tick clock
    tick_en = 1;
    set_cfg(1, 0, 4'b0011);
    mst_xfer(8'h3E, 8'hD2, "R2", 1);
    check_eq("R2", "half period timer", half_cyc, 5);
    tick_en = 0;

    // R4: idle high
    set_cfg(1, 1, 4'b0000);
    check_eq("R4", "idle high sck_o", sck_o, 1);
    mst_xfer(8'h5A, 8'hC3, "R4", 1);
    check_eq("R4", "idle high after transfer", sck_o, 1);

    // R7: write collision
    set_cfg(1, 0, 4'b0001);
    resp = 8'h99; ridx = 0; mon_on = 1;
    exp_tx.push_back(8'h66); exp_tx_req.push_back("R7");
    exp_rx.push_back(8'h99); exp_rx_req.push_back("R7");
    write_byte(8'h66);
    repeat (10) @(negedge clk);
    check_eq("R7", "tx_ready while busy", tx_ready, 0);
    write_byte(8'h11);
    check_eq("R7", "wcol set", wcol, 1);
    wait_idle();
    mon_on = 0;
    check_eq("R7", "wcol sticky", wcol, 1);
    @(negedge clk); wcol_clr = 1; @(negedge clk); wcol_clr = 0;
    check_eq("R7", "wcol cleared", wcol, 0);

    // R9: master overwrites without overflow
    set_cfg(1, 0, 4'b0000);
    rx_ready = 0;
    mst_xfer(8'h01, 8'h44, "R9", 0);
    mst_xfer(8'h02, 8'h55, "R9", 0);
    check_eq("R9", "no rov in master", rov, 0);
    check_eq("R9", "buffer holds newest", rx_data, 8'h55);
    exp_rx.push_back(8'h55); exp_rx_req.push_back("R9");
    rx_ready = 1;
    repeat (2) @(negedge clk);
    check_eq("R3", "rx_valid cleared by read", rx_valid, 0);

    // R5: free slave
    set_cfg(1, 0, 4'b0101);
    check_eq("R5", "slave sdo_oe", sdo_oe, 1);
    check_eq("R5", "slave sck_oe", sck_oe, 0);
    write_byte(8'h96);
    exp_rx.push_back(8'h5A); exp_rx_req.push_back("R5");
    slv_bits(8'h5A, 8);
    check_eq("R5", "slave tx byte", scap, 8'h96);

    // R8: slave overflow drops the new byte
    rx_ready = 0;
    slv_bits(8'h11, 8);
    slv_bits(8'h22, 8);
    check_eq("R8", "rov set", rov, 1);
    check_eq("R8", "buffer keeps older", rx_data, 8'h11);
    @(negedge clk); rov_clr = 1; @(negedge clk); rov_clr = 0;
    check_eq("R8", "rov cleared", rov, 0);
    exp_rx.push_back(8'h11); exp_rx_req.push_back("R8");
    rx_ready = 1;
    repeat (3) @(negedge clk);

    // R6: select-gated slave
    set_cfg(1, 0, 4'b0100);
    check_eq("R6", "deselected sdo_oe", sdo_oe, 0);
    slv_bits(8'hAA, 8);
    check_eq("R6", "deselected no byte", rx_valid, 0);
    @(negedge clk); ss_n_i = 0; repeat (4) @(negedge clk);
    check_eq("R6", "selected sdo_oe", sdo_oe, 1);
    slv_bits(8'hFF, 4);
    ss_n_i = 1; repeat (6) @(negedge clk);
    ss_n_i = 0; repeat (4) @(negedge clk);
    exp_rx.push_back(8'hC3); exp_rx_req.push_back("R6");
    slv_bits(8'hC3, 8);
    ss_n_i = 1;
    repeat (4) @(negedge clk);

    // R10: reserved modes
    set_cfg(1, 0, 4'b0110);
    check_eq("R10", "reserved tx_ready", tx_ready, 0);
    write_byte(8'hFF);
    repeat (40) @(negedge clk);
    check_eq("R10", "reserved wcol", wcol, 0);
    check_eq("R10", "reserved sck_oe", sck_oe, 0);
    check_eq("R10", "reserved rx_valid", rx_valid, 0);
    set_cfg(1, 0, 4'b1111);
    check_eq("R10", "mode F tx_ready", tx_ready, 0);

    check_eq("R3", "tx scoreboard drained", exp_tx.size(), 0);
    check_eq("R3", "rx scoreboard drained", exp_rx.size(), 0);
    finish_run();
  end
endmodule